// File: doc/BRIEF.md
# Double-Buffered Multichannel PWM Timer

This block is a timer/counter that produces pulse-width-modulated outputs on several compare channels. All channels share one period value and one counter. A power-of-two prescaler divides the input clock. The counter runs in one of two ways. In single-slope mode it counts up and wraps, which gives edge-aligned pulses. In dual-slope mode it counts up and then down, which gives pulses centred on the count of zero.

Software loads the period and compare values through a simple register write port. Each value can be written in one of two ways. A direct write changes the active value at once. A buffered write parks the value in a shadow register. The shadow register is copied into the active register only at the cycle boundary, so a change made in the middle of a cycle cannot distort the pulse already in progress. Each register has a busy flag, which software can poll after a write.

Top module: `pwm_dbuf_timer`

## Requirements
- R1: After reset all outputs are low, the count is 0, `busy` is all zero and `per_rd` reads all ones (the reset period).
- R2: Register addresses are: 0 control, 1 period (direct), 2 period buffer, 3+i compare i (direct), 3+NCH+i compare buffer i. A write to address k raises `busy[k]` on the cycle after the write. It clears one cycle later, and no other busy bit rises.
- R3: The control register fields are: bit 0 enable, bit 1 slope (0 single, 1 dual), bits 4:2 prescale exponent k. While enable is 0 the count holds its value.
- R4: In single-slope mode the count runs 0..PER and then wraps to 0. The period is (PER+1)·2^k input clocks.
- R5: Output i is high while the count is below compare i. A compare of 0 keeps the output low, and a compare of PER or more keeps it high.
- R6: A direct write to the period or to a compare register takes effect at the next clock edge. `per_rd` shows the period value in use.
- R7: A buffered write does not change the active value until the next update event. In single-slope mode the update event is the wrap to 0. In dual-slope mode it is the arrival at 0.
- R8: An update event with no buffered write since the previous transfer leaves the active value unchanged.
- R9: A buffered write in the same cycle as an update event works as follows. The value pending before that cycle is transferred, and the new value waits for the following update event.
- R10: In dual-slope mode the count rises to PER and then falls to 0. The period is 2·PER·2^k clocks, and the pulse is centred on 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register address |
| wr_data | input | CNT_W | Write data |
| busy | output | NREG | Per-register busy flags |
| per_rd | output | CNT_W | Period value in use |
| cnt_o | output | CNT_W | Current count |
| pwm_o | output | NCH | Channel outputs |

## Verification
Two events can fall on the same clock edge: a buffered write and the update event that would consume the buffer. The bench provokes this collision. It first places a value in a compare buffer during a cycle. It then writes a second value on the last count before the wrap. The bench judges the result by the high-time of the next two periods. The first period must show the earlier value and the second period must show the later one. A wrong priority would show the later value at once or would lose it.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    localparam int PSC_W     = 3;
    localparam int CTRL_W    = PSC_W + 2;
    localparam int ADDR_CTRL = 0;
    localparam int ADDR_PER  = 1;
    localparam int ADDR_PERB = 2;
    localparam int ADDR_CC0  = 3;

    typedef enum logic { SLOPE_SINGLE = 1'b0, SLOPE_DUAL = 1'b1 } slope_e;
    typedef enum logic { DIR_UP = 1'b0, DIR_DOWN = 1'b1 } dir_e;

    typedef struct packed {
        logic [PSC_W-1:0] psc;
        slope_e           slope;
        logic             run;
    } ctrl_t;

    function automatic int ccb_base(input int nch);
        return ADDR_CC0 + nch;
    endfunction

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
    import pwm_pkg::*;
#(
    parameter int SEL_W = PSC_W,
    localparam int DIV_W = (1 << SEL_W) - 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);

    logic [DIV_W-1:0] pcnt;
    logic [DIV_W-1:0] mask;

    assign mask = ~({DIV_W{1'b1}} << sel);
    assign tick = run && ((pcnt & mask) == mask);

    always_ff @(posedge clk) begin
        if (rst || !run) pcnt <= '0;
        else             pcnt <= pcnt + 1'b1;
    end

    // R3
    halt_no_tick_chk: assert property (@(posedge clk) disable iff (rst)
        !run |-> !tick);

endmodule

// File: rtl/pwm_counter.sv
module pwm_counter
    import pwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  slope_e           slope,
    input  logic [CNT_W-1:0] per,
    output logic [CNT_W-1:0] cnt,
    output logic             update
);

    dir_e             dir, nxt_dir;
    logic [CNT_W-1:0] nxt;

    always_comb begin
        nxt     = cnt;
        nxt_dir = dir;
        if (slope == SLOPE_SINGLE) begin
            nxt_dir = DIR_UP;
            nxt     = (cnt >= per) ? '0 : cnt + 1'b1;
        end else if (dir == DIR_UP) begin
            if (cnt >= per) begin
                nxt_dir = DIR_DOWN;
                nxt     = (cnt == '0) ? '0 : cnt - 1'b1;
            end else begin
                nxt = cnt + 1'b1;
            end
        end else begin
            if (cnt == '0) begin
                nxt_dir = DIR_UP;
                nxt     = (per == '0) ? '0 : CNT_W'(1);
            end else begin
                nxt = cnt - 1'b1;
            end
        end
    end

    assign update = tick && (nxt == '0) && ((cnt != '0) || (per == '0));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            dir <= DIR_UP;
        end else if (tick) begin
            cnt <= nxt;
            dir <= nxt_dir;
        end
    end

    // R3
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(cnt));
    // R4
    single_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        tick && slope == SLOPE_SINGLE && cnt >= per |=> cnt == '0);
    // R10
    dual_fall_chk: assert property (@(posedge clk) disable iff (rst)
        tick && slope == SLOPE_DUAL && dir == DIR_DOWN && cnt != '0
        |=> cnt == $past(cnt) - 1'b1);

endmodule

// File: rtl/pwm_shadow_reg.sv
module pwm_shadow_reg #(
    parameter int         W       = 16,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_act,
    input  logic         wr_buf,
    input  logic [W-1:0] wdata,
    input  logic         update,
    output logic [W-1:0] act
);

    logic [W-1:0] pend;
    logic         pend_vld;

    always_ff @(posedge clk) begin
        if (rst) begin
            act      <= RST_VAL;
            pend     <= RST_VAL;
            pend_vld <= 1'b0;
        end else begin
            if (wr_act)                    act <= wdata;
            else if (update && pend_vld)   act <= pend;
            if (wr_buf) begin
                pend     <= wdata;
                pend_vld <= 1'b1;
            end else if (update) begin
                pend_vld <= 1'b0;
            end
        end
    end

    // R7
    act_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !update && !wr_act |=> $stable(act));
    // R9
    transfer_chk: assert property (@(posedge clk) disable iff (rst)
        update && pend_vld && !wr_act |=> act == $past(pend));
    // R8
    no_pend_keep_chk: assert property (@(posedge clk) disable iff (rst)
        update && !pend_vld && !wr_act |=> $stable(act));

endmodule

// File: rtl/pwm_compare.sv
module pwm_compare #(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] cc,
    input  logic [CNT_W-1:0] per,
    output logic             lvl
);

    assign lvl = (cc != '0) && ((cnt < cc) || (cc >= per));

endmodule

// File: rtl/pwm_dbuf_timer.sv
module pwm_dbuf_timer
    import pwm_pkg::*;
#(
    parameter int  NCH    = 4,
    parameter int  CNT_W  = 16,
    localparam int NREG   = ADDR_CC0 + 2 * NCH,
    localparam int ADDR_W = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic [NREG-1:0]   busy,
    output logic [CNT_W-1:0]  per_rd,
    output logic [CNT_W-1:0]  cnt_o,
    output logic [NCH-1:0]    pwm_o
);

    localparam int CCB0 = ccb_base(NCH);

    logic [NREG-1:0]  hit;
    logic [NREG-1:0]  busy_q;
    ctrl_t            ctrl_q;
    logic             tick;
    logic             update;
    logic [CNT_W-1:0] per_act;
    logic [CNT_W-1:0] cnt;

    for (genvar k = 0; k < NREG; k++) begin : g_dec
        assign hit[k] = wr_en && (wr_addr == ADDR_W'(k));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= '0;
            ctrl_q <= '0;
        end else begin
            busy_q <= hit;
            if (hit[ADDR_CTRL]) ctrl_q <= ctrl_t'(wr_data[CTRL_W-1:0]);
        end
    end

    pwm_prescaler #(.SEL_W(PSC_W)) u_psc (
        .clk (clk), .rst (rst), .run (ctrl_q.run), .sel (ctrl_q.psc), .tick (tick)
    );

    pwm_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk (clk), .rst (rst), .tick (tick), .slope (ctrl_q.slope),
        .per (per_act), .cnt (cnt), .update (update)
    );

    pwm_shadow_reg #(.W(CNT_W), .RST_VAL({CNT_W{1'b1}})) u_per (
        .clk (clk), .rst (rst), .wr_act (hit[ADDR_PER]), .wr_buf (hit[ADDR_PERB]),
        .wdata (wr_data), .update (update), .act (per_act)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic [CNT_W-1:0] cc_act;
        pwm_shadow_reg #(.W(CNT_W), .RST_VAL('0)) u_cc (
            .clk (clk), .rst (rst), .wr_act (hit[ADDR_CC0 + i]),
            .wr_buf (hit[CCB0 + i]), .wdata (wr_data), .update (update),
            .act (cc_act)
        );
        pwm_compare #(.CNT_W(CNT_W)) u_cmp (
            .cnt (cnt), .cc (cc_act), .per (per_act), .lvl (pwm_o[i])
        );
    end

    assign busy   = busy_q;
    assign per_rd = per_act;
    assign cnt_o  = cnt;

    // R2
    busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en && wr_addr == ADDR_W'(ADDR_PER) |=> busy[ADDR_PER]);
    // R2
    busy_clear_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> busy == '0);
    // R6
    per_direct_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en && wr_addr == ADDR_W'(ADDR_PER) |=> per_rd == $past(wr_data));

endmodule

// File: tb/pwm_dbuf_timer_tb.sv
module pwm_dbuf_timer_tb;

    localparam int NCH = 4;
    localparam int W   = 16;
    localparam int NR  = 3 + 2 * NCH;
    localparam int A_CTRL = 0, A_PER = 1, A_PERB = 2, A_CC = 3, A_CCB = 3 + NCH;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [3:0]    wr_addr = '0;
    logic [W-1:0]  wr_data = '0;
    logic [NR-1:0] busy;
    logic [W-1:0]  per_rd, cnt_o;
    logic [NCH-1:0] pwm_o;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    pwm_dbuf_timer #(.NCH(NCH), .CNT_W(W)) u_dut (
        .clk (clk), .rst (rst), .wr_en (wr_en), .wr_addr (wr_addr),
        .wr_data (wr_data), .busy (busy), .per_rd (per_rd), .cnt_o (cnt_o),
        .pwm_o (pwm_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        wr_en   = 1'b1;
        wr_addr = 4'(a);
        wr_data = W'(d);
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic wait_cnt(input int v);
        while (cnt_o != W'(v)) @(negedge clk);
    endtask

    task automatic count_high(input int ch, input int n, output int hi);
        hi = 0;
        for (int s = 0; s < n; s++) begin
            if (pwm_o[ch]) hi++;
            @(negedge clk);
        end
    endtask

    task automatic measure_period(output int n);
        n = 0;
        while (cnt_o == '0) @(negedge clk);
        while (cnt_o != '0) @(negedge clk);
        while (cnt_o == '0) begin n++; @(negedge clk); end
        while (cnt_o != '0) begin n++; @(negedge clk); end
    endtask

    task automatic t_reset;
        chk("R1 pwm", int'(pwm_o), 0);
        chk("R1 cnt", int'(cnt_o), 0);
        chk("R1 busy", int'(busy), 0);
        chk("R1 per_rd", int'(per_rd), 16'hFFFF);
    endtask

    task automatic t_busy;
        wr(A_PER, 9);
        chk("R2 busy set", int'(busy), 1 << A_PER);
        chk("R6 per direct", int'(per_rd), 9);
        @(negedge clk);
        chk("R2 busy clear", int'(busy), 0);
    endtask

    task automatic t_single;
        int hi, mx, p;
        wr(A_CC + 0, 3);
        wr(A_CC + 1, 0);
        wr(A_CC + 2, 9);
        wr(A_CC + 3, 5);
        wr(A_CTRL, 1);
        measure_period(p);
        chk("R4 period div1", p, 10);
        wait_cnt(0);
        mx = 0;
        for (int s = 0; s < 10; s++) begin
            if (int'(cnt_o) > mx) mx = int'(cnt_o);
            @(negedge clk);
        end
        chk("R4 max count", mx, 9);
        count_high(0, 10, hi); chk("R5 ch0 cc=3", hi, 3);
        count_high(1, 10, hi); chk("R5 ch1 cc=0", hi, 0);
        count_high(2, 10, hi); chk("R5 ch2 cc=per", hi, 10);
        count_high(3, 10, hi); chk("R5 ch3 cc=5", hi, 5);
    endtask

    task automatic t_prescale_hold;
        int p, held;
        wr(A_CTRL, (2 << 2) | 1);
        measure_period(p);
        chk("R3 R4 period div4", p, 40);
        wr(A_CTRL, 0);
        held = int'(cnt_o);
        repeat (6) @(negedge clk);
        chk("R3 hold while disabled", int'(cnt_o), held);
        wr(A_CTRL, 1);
    endtask

    task automatic t_buffered_cc;
        int hi, bad;
        wait_cnt(2);
        wr(A_CCB + 0, 7);
        bad = 0;
        while (cnt_o != '0) begin
            if (pwm_o[0]) bad++;
            @(negedge clk);
        end
        chk("R7 old cc kept mid-cycle", bad, 0);
        count_high(0, 10, hi);
        chk("R7 new cc after wrap", hi, 7);
    endtask

    task automatic t_buffered_per;
        int p;
        wait_cnt(2);
        wr(A_PERB, 4);
        chk("R7 per unchanged before update", int'(per_rd), 9);
        wait_cnt(0);
        chk("R7 per after update", int'(per_rd), 4);
        measure_period(p);
        chk("R7 buffered period", p, 5);
    endtask

    task automatic t_no_reload;
        int p;
        wr(A_PER, 9);
        chk("R6 direct per", int'(per_rd), 9);
        measure_period(p);
        measure_period(p);
        chk("R8 period unchanged", p, 10);
        chk("R8 per_rd unchanged", int'(per_rd), 9);
    endtask

    task automatic t_direct_cc;
        int hi;
        wait_cnt(4);
        wr(A_CC + 0, 1);
        chk("R6 direct cc immediate", int'(pwm_o[0]), 0);
        wait_cnt(0);
        count_high(0, 10, hi);
        chk("R6 direct cc period", hi, 1);
    endtask

    task automatic t_collision;
        int hi;
        wait_cnt(3);
        wr(A_CCB + 1, 2);
        wait_cnt(9);
        wr(A_CCB + 1, 6);
        count_high(1, 10, hi);
        chk("R9 pending value transferred", hi, 2);
        count_high(1, 10, hi);
        chk("R9 new value next update", hi, 6);
    endtask

    task automatic t_dual;
        int p, hi, mx;
        wr(A_CTRL, 0);
        wr(A_PER, 4);
        wr(A_CC + 1, 0);
        wr(A_CC + 2, 2);
        wr(A_CC + 3, 4);
        wr(A_CTRL, 3);
        measure_period(p);
        chk("R10 dual period", p, 8);
        wait_cnt(0);
        mx = 0;
        for (int s = 0; s < 8; s++) begin
            if (int'(cnt_o) > mx) mx = int'(cnt_o);
            @(negedge clk);
        end
        chk("R10 dual peak", mx, 4);
        count_high(2, 8, hi); chk("R10 centred cc=2", hi, 3);
        count_high(3, 8, hi); chk("R10 R5 cc=per", hi, 8);
        count_high(1, 8, hi); chk("R10 R5 cc=0", hi, 0);
        wait_cnt(3);
        wr(A_CCB + 2, 3);
        wait_cnt(0);
        count_high(2, 8, hi);
        chk("R7 R10 dual buffered cc", hi, 5);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_busy();
        t_single();
        t_prescale_hold();
        t_buffered_cc();
        t_buffered_per();
        t_no_reload();
        t_direct_cc();
        t_collision();
        t_dual();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule